// File: doc/BRIEF.md
# Boot Mode Stall Controller

This block sequences the start of a processor core after reset. An active-low external reset is turned into an active-high internal reset that asserts at once and releases in step with the clock. When the internal reset releases, the rest of the system runs but the core is held stalled. The core is freed by a condition that depends on a strapped boot mode: a host setting the host-interrupt bit, an emulator request, or the end of a ROM block copy.

The same host-interrupt bit is the host's doorbell to the running core. While the core is stalled, a set of the bit is latched but never raised as a core interrupt. Once the core runs, a set raises one interrupt only when the bit was clear. The core must clear the bit before the next interrupt can be taken. In emulation boot the controller sets the bit itself if it is still clear. It also raises a breakpoint-at-zero request before it frees the core.

Top module: `boot_stall_ctrl`

## Requirements
- R1: `int_rst` goes high as soon as `ext_rst_n` is low, and goes low on the second rising clock edge after `ext_rst_n` returns high.
- R2: `core_stall` is high from the first clock edge of internal reset until the release edge of the selected boot mode. It is low after that edge until the next internal reset.
- R3: `boot_mode` is decoded as 00 host, 01 emulation, 10 ROM and 11 host. It is captured on the clock edge at which `int_rst` falls, and later changes have no effect.
- R4: In host boot, a `host_int_set` pulse sets `host_int_flag` at its edge, and `core_stall` falls at the following edge.
- R5: `emu_req` and `copy_done` have no effect on the stall in host boot. `host_int_set` does not release the stall in emulation or ROM boot.
- R6: In emulation boot, `emu_req` during the stall sets `bkpt_zero_req` and `host_int_flag` at that edge, and `core_stall` falls at the next edge. `bkpt_zero_req` stays high until the next internal reset.
- R7: In ROM boot, `core_stall` falls at the edge where `copy_done` is high during the stall.
- R8: `start_at_zero` is high for exactly the first cycle in which `core_stall` is low.
- R9: A set of the host-interrupt bit while the core is stalled latches `host_int_flag` but never pulses `core_int`.
- R10: While the core runs, `host_int_set` with the flag clear sets the flag and pulses `core_int` for one cycle. A set while the flag is high is ignored. `core_int_clr` clears the flag and wins over a set in the same cycle. `core_int_clr` is ignored during the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst_n | input | 1 | External reset, active low, asynchronous |
| boot_mode | input | 2 | Strapped boot mode |
| host_int_set | input | 1 | Host write of 1 to the host-interrupt bit |
| core_int_clr | input | 1 | Core clears the host-interrupt bit |
| emu_req | input | 1 | Emulator release request |
| copy_done | input | 1 | ROM block copy finished |
| int_rst | output | 1 | Internal reset, active high |
| core_stall | output | 1 | Holds the core stalled |
| start_at_zero | output | 1 | One-cycle start-from-address-0 strobe |
| bkpt_zero_req | output | 1 | Breakpoint at address 0 request |
| host_int_flag | output | 1 | Latched host-interrupt bit |
| core_int | output | 1 | One-cycle interrupt to the core |

## Verification
The assertions take the request inputs to be synchronous to `clk`. They also take `ext_rst_n` to be the only asynchronous input, and they are turned off while `int_rst` or the external reset is active. The stimulus changes every input just after a falling clock edge. It raises each request as a single-cycle pulse, except where a pulse is held on purpose to show that a repeated set is ignored. It drops `ext_rst_n` only between scenarios, so all three modes and the reserved code are each started from a clean internal reset.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [1:0] {
    BM_HOST     = 2'b00,
    BM_EMU      = 2'b01,
    BM_ROM      = 2'b10,
    BM_HOST_ALT = 2'b11
  } boot_mode_e;

  typedef enum logic [1:0] {
    SQ_STALL = 2'b00,
    SQ_ARM   = 2'b01,
    SQ_RUN   = 2'b10
  } seq_state_e;

  function automatic logic is_host_boot(input boot_mode_e m);
    return (m == BM_HOST) || (m == BM_HOST_ALT);
  endfunction
endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic ext_rst_n,
  output logic rst_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) chain <= '0;
        else            chain <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) chain <= '0;
        else            chain <= {chain[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_o = ~chain[STAGES-1];
endmodule

// File: rtl/boot_hint_flag.sv
module boot_hint_flag (
  input  logic clk,
  input  logic rst,
  input  logic running,
  input  logic set_i,
  input  logic clr_i,
  input  logic emu_set_i,
  output logic flag_o,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (running) begin
        if (clr_i) begin
          flag_o <= 1'b0;
        end else if (set_i && !flag_o) begin
          flag_o <= 1'b1;
          irq_o  <= 1'b1;
        end
      end else if (set_i || emu_set_i) begin
        flag_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/boot_stall_seq.sv
module boot_stall_seq
  import boot_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] boot_mode_i,
  input  logic       flag_i,
  input  logic       emu_req_i,
  input  logic       copy_done_i,
  output logic       core_stall_o,
  output logic       start_zero_o,
  output logic       bkpt_o,
  output logic       running_o,
  output logic       emu_set_o
);
  seq_state_e state;
  boot_mode_e mode_q;
  logic       release_now;

  always_comb begin
    release_now = 1'b0;
    if (state == SQ_ARM) begin
      release_now = 1'b1;
    end else if (state == SQ_STALL) begin
      if (is_host_boot(mode_q)) release_now = flag_i;
      else if (mode_q == BM_ROM) release_now = copy_done_i;
    end
  end

  assign emu_set_o = (state == SQ_STALL) && (mode_q == BM_EMU) && emu_req_i;
  assign running_o = (state == SQ_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q       <= boot_mode_e'(boot_mode_i);
      state        <= SQ_STALL;
      core_stall_o <= 1'b1;
      start_zero_o <= 1'b0;
      bkpt_o       <= 1'b0;
    end else begin
      start_zero_o <= 1'b0;
      if (emu_set_o) begin
        state  <= SQ_ARM;
        bkpt_o <= 1'b1;
      end else if (release_now) begin
        state        <= SQ_RUN;
        core_stall_o <= 1'b0;
        start_zero_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/boot_stall_ctrl.sv
module boot_stall_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       ext_rst_n,
  input  logic [1:0] boot_mode,
  input  logic       host_int_set,
  input  logic       core_int_clr,
  input  logic       emu_req,
  input  logic       copy_done,
  output logic       int_rst,
  output logic       core_stall,
  output logic       start_at_zero,
  output logic       bkpt_zero_req,
  output logic       host_int_flag,
  output logic       core_int
);
  logic running;
  logic emu_set;

  boot_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .ext_rst_n(ext_rst_n),
    .rst_o    (int_rst)
  );

  boot_stall_seq u_seq (
    .clk         (clk),
    .rst         (int_rst),
    .boot_mode_i (boot_mode),
    .flag_i      (host_int_flag),
    .emu_req_i   (emu_req),
    .copy_done_i (copy_done),
    .core_stall_o(core_stall),
    .start_zero_o(start_at_zero),
    .bkpt_o      (bkpt_zero_req),
    .running_o   (running),
    .emu_set_o   (emu_set)
  );

  boot_hint_flag u_flag (
    .clk      (clk),
    .rst      (int_rst),
    .running  (running),
    .set_i    (host_int_set),
    .clr_i    (core_int_clr),
    .emu_set_i(emu_set),
    .flag_o   (host_int_flag),
    .irq_o    (core_int)
  );
endmodule

// File: rtl/boot_stall_chk.sv
module boot_stall_chk (
  input logic       clk,
  input logic       ext_rst_n,
  input logic [1:0] boot_mode,
  input logic       host_int_set,
  input logic       core_int_clr,
  input logic       emu_req,
  input logic       copy_done,
  input logic       int_rst,
  input logic       core_stall,
  input logic       start_at_zero,
  input logic       bkpt_zero_req,
  input logic       host_int_flag,
  input logic       core_int
);
  AST_STALL_AFTER_RESET: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $past(int_rst) |-> core_stall); // R2
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (int_rst)
    start_at_zero |=> !start_at_zero); // R8
  AST_START_ON_RELEASE: assert property (@(posedge clk) disable iff (int_rst)
    start_at_zero |-> $fell(core_stall)); // R8
  AST_BKPT_WHILE_STALLED: assert property (@(posedge clk) disable iff (int_rst)
    $rose(bkpt_zero_req) |-> core_stall && host_int_flag); // R6
  AST_BKPT_HELD: assert property (@(posedge clk) disable iff (int_rst)
    bkpt_zero_req |=> bkpt_zero_req); // R6
  AST_NO_INT_IN_STALL: assert property (@(posedge clk) disable iff (int_rst)
    core_int |-> !core_stall); // R9
  AST_NO_REPEAT_INT: assert property (@(posedge clk) disable iff (int_rst)
    core_int |-> !$past(host_int_flag) && host_int_flag); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (int_rst)
    host_int_flag && !core_int_clr |=> host_int_flag); // R10
  AST_STALL_STAYS_LOW: assert property (@(posedge clk) disable iff (int_rst)
    !core_stall |=> !core_stall); // R2
endmodule

bind boot_stall_ctrl boot_stall_chk u_chk (.*);

// File: tb/sim_boot_stall_ctrl.sv
`timescale 1ns/1ps
module sim_boot_stall_ctrl;
  logic clk = 1'b0;
  logic ext_rst_n = 1'b0;
  logic [1:0] boot_mode = 2'b00;
  logic host_int_set = 1'b0, core_int_clr = 1'b0, emu_req = 1'b0, copy_done = 1'b0;
  logic int_rst, core_stall, start_at_zero, bkpt_zero_req, host_int_flag, core_int;

  int total = 0;
  int bad = 0;
  bit cmp_on = 1'b0;
  int wd = 0;

  always #2.5 clk = ~clk;

  boot_stall_ctrl u0 (.*);

  // behavioural reference model
  int m_cnt = 0;
  int m_mode = 0;
  int m_st = 0; // 0 stall, 1 armed, 2 running
  bit m_stall = 1, m_start = 0, m_bkpt = 0, m_flag = 0, m_int = 0;

  always @(negedge ext_rst_n) m_cnt = 0;

  always @(posedge clk) begin
    bit o_rst;
    bit o_flag;
    int o_st;
    o_rst = (m_cnt < 2);
    o_flag = m_flag;
    o_st = m_st;
    if (ext_rst_n && m_cnt < 2) m_cnt = m_cnt + 1;
    if (o_rst) begin
      m_mode = boot_mode; m_st = 0; m_stall = 1; m_start = 0;
      m_bkpt = 0; m_flag = 0; m_int = 0;
    end else begin
      m_start = 0; m_int = 0;
      if (o_st == 2) begin
        if (core_int_clr) m_flag = 0;
        else if (host_int_set && !o_flag) begin m_flag = 1; m_int = 1; end
      end else begin
        if (host_int_set) m_flag = 1;
        if (o_st == 0 && m_mode == 1 && emu_req) m_flag = 1;
      end
      if (o_st == 0 && m_mode == 1 && emu_req) begin
        m_st = 1; m_bkpt = 1;
      end else if ((o_st == 1) ||
                   (o_st == 0 && (m_mode == 0 || m_mode == 3) && o_flag) ||
                   (o_st == 0 && m_mode == 2 && copy_done)) begin
        m_st = 2; m_stall = 0; m_start = 1;
      end
    end
  end

  task automatic chk(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R1", int_rst, (m_cnt < 2));
      chk("R2", core_stall, m_stall);
      chk("R8", start_at_zero, m_start);
      chk("R6", bkpt_zero_req, m_bkpt);
      chk("R10", host_int_flag, m_flag);
      chk("R9", core_int, m_int);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic pulse_set();  host_int_set = 1; step(); host_int_set = 0; endtask
  task automatic pulse_clr();  core_int_clr = 1; step(); core_int_clr = 0; endtask

  task automatic do_reset(input logic [1:0] mode);
    step();
    ext_rst_n = 0;
    #1 chk("R1", int_rst, 1'b1);
    step(3);
    boot_mode = mode;
    ext_rst_n = 1;
    step();
    chk("R1", int_rst, 1'b1);
    step();
    chk("R1", int_rst, 1'b0);
    chk("R2", core_stall, 1'b1);
  endtask

  initial begin
    step(2);
    cmp_on = 1;
    // host boot with ignored requests first
    do_reset(2'b00);
    chk("R2", start_at_zero, 1'b0);
    emu_req = 1; step(); emu_req = 0;
    copy_done = 1; step(); copy_done = 0;
    step(2);
    chk("R5", core_stall, 1'b1);
    chk("R5", bkpt_zero_req, 1'b0);
    core_int_clr = 1; step(); core_int_clr = 0; // ignored in stall (R10)
    pulse_set();
    chk("R4", host_int_flag, 1'b1);
    chk("R9", core_int, 1'b0);
    chk("R4", core_stall, 1'b1);
    step();
    chk("R4", core_stall, 1'b0);
    chk("R8", start_at_zero, 1'b1);
    step();
    chk("R8", start_at_zero, 1'b0);
    pulse_set(); // flag still high: ignored
    chk("R10", core_int, 1'b0);
    pulse_clr();
    chk("R10", host_int_flag, 1'b0);
    pulse_set();
    chk("R10", core_int, 1'b1);
    step();
    chk("R10", core_int, 1'b0);
    pulse_clr();
    host_int_set = 1; core_int_clr = 1; step(); host_int_set = 0; core_int_clr = 0;
    chk("R10", host_int_flag, 1'b0);
    host_int_set = 1; step(3); host_int_set = 0; // held set: one interrupt only
    step(2);

    // emulation boot, host bit already set during the stall
    do_reset(2'b01);
    pulse_set();
    step(3);
    chk("R5", core_stall, 1'b1);
    chk("R9", core_int, 1'b0);
    emu_req = 1; step(); emu_req = 0;
    chk("R6", bkpt_zero_req, 1'b1);
    chk("R6", core_stall, 1'b1);
    step();
    chk("R6", core_stall, 1'b0);
    pulse_set();
    chk("R10", core_int, 1'b0);
    pulse_clr(); pulse_set();
    chk("R10", core_int, 1'b1);
    step(4);
    chk("R6", bkpt_zero_req, 1'b1);

    // emulation boot with flag clear
    do_reset(2'b01);
    step(2);
    emu_req = 1; step(); emu_req = 0;
    chk("R6", host_int_flag, 1'b1);
    step(3);

    // ROM boot, mode pins changed after capture
    do_reset(2'b10);
    boot_mode = 2'b00;
    pulse_set();
    step(3);
    chk("R3", core_stall, 1'b1);
    chk("R5", core_stall, 1'b1);
    copy_done = 1; step(); copy_done = 0;
    chk("R7", core_stall, 1'b0);
    chk("R7", start_at_zero, 1'b1);
    step(3);

    // reserved code decodes as host boot
    do_reset(2'b11);
    boot_mode = 2'b10;
    copy_done = 1; step(); copy_done = 0;
    chk("R3", core_stall, 1'b1);
    pulse_set(); step();
    chk("R3", core_stall, 1'b0);
    step(2);

    // reset in the middle of a run
    ext_rst_n = 0;
    #1 chk("R1", int_rst, 1'b1);
    step(2);
    chk("R2", core_stall, 1'b1);
    chk("R10", host_int_flag, 1'b0);
    ext_rst_n = 1;
    step(4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule